// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block runs one external memory or I/O transfer at a time over a shared bus. In the first clock of a transfer, the low lines carry the lower part of the address and the upper lines carry the upper part. After that first clock, the low lines turn over to data and the upper lines switch to status. The status holds the segment selector that came with the request. The block also drives the strobes an external system needs to use this bus: a one-clock address latch pulse, active-low read and write strobes, an active-low enable for the data buffers, a buffer direction select and a memory/IO select. It stretches the transfer with wait states while the addressed device holds its ready input low.

On the inside, a simple valid/ready handshake accepts a request carrying the address, write data, direction, memory/IO flag and segment code. A request is taken only while the sequencer is idle. When the transfer finishes, `done` pulses for one clock and `rdata` holds the value that was read. The state machine has six named states: IDLE, T1 (address), T2 (strobe begins), T3 (ready sampled), TW (wait) and T4 (finish). It has these transitions:
- IDLE→T1 on an accepted request.
- T1→T2 and T2→T3, unconditionally.
- T3→TW and TW→TW while ready is low.
- T3→T4 and TW→T4 when ready is high.
- T4→IDLE, unconditionally.

Top module: `madb_seq`

## Requirements
- R1: A request is accepted only in a cycle where `req_ready` is high, which is only in IDLE. `req_ready` is low from T1 through T4. Request fields that change while a transfer is running do not affect that transfer.
- R2: In T1, `ale` is high for exactly one clock. `ad_out` equals address bits 15..0, `as_out` equals address bits 19..16, and `ad_oe` is 1. `rd_n`, `wr_n` and `den_n` are all 1.
- R3: From T2 through T4, `as_out` carries status. Bits 1..0 hold the segment code (00 extra, 01 stack, 10 code, 11 data) and bits 3..2 are 0.
- R4: On a write, `ad_oe` is 1 and `ad_out` equals the write data from T2 through T4. `wr_n` is low in T2, T3 and every TW, and `rd_n` stays high.
- R5: On a read, `ad_oe` is 0 from T2 through T4. `rd_n` is low in T2, T3 and every TW, and `wr_n` stays high.
- R6: `den_n` is low from T2 through T4. It is high in T1 and in IDLE.
- R7: `dir` is 1 on a write and 0 on a read throughout T1–T4, and 0 in IDLE.
- R8: `mio` is 1 for a memory transfer and 0 for an I/O transfer throughout T1–T4.
- R9: Each clock in which `ready` is sampled low in T3 or TW adds one TW. A transfer with N wait states lasts 4+N clocks.
- R10: Read data is taken from `ad_in` at the end of the last T3/TW, when `ready` is high. `done` is high only during T4, for one clock, and `rdata` is valid while `done` is high.
- R11: After reset the block is in IDLE. `req_ready` is 1, `done` and `ale` are 0, and all active-low strobes are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_mem | input | 1 | 1 = memory, 0 = I/O |
| req_seg | input | 2 | Segment code for status |
| req_addr | input | 20 | Transfer address |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-clock end-of-transfer pulse |
| rdata | output | 16 | Captured read data |
| ale | output | 1 | Address latch pulse |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data buffer enable, active low |
| dir | output | 1 | Buffer direction, 1 = outbound |
| mio | output | 1 | 1 = memory, 0 = I/O |
| ad_out | output | 16 | Shared low lines, outbound value |
| ad_oe | output | 1 | Drive enable for shared low lines |
| as_out | output | 4 | Upper address / status lines |
| ad_in | input | 16 | Shared low lines, inbound value |
| ready | input | 1 | Device acknowledge, low inserts wait |

## Verification
The assertions take `ready` and `ad_in` to be synchronous levels that settle before each rising edge. They also take `req_valid` to be a level that may stay high while the sequencer is busy. The bench drives every input on the falling edge. It models the device's `ready` as a count from the address pulse, so it is low for exactly the number of wait states planned for that transfer. While `ready` is low, the bench drives a junk value on `ad_in`, so a capture taken too early shows up as wrong data. The bench holds `req_valid` high with the next request's fields while a transfer is still running.

// File: rtl/madb_pkg.sv
package madb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_TW   = 3'd4,
        ST_T4   = 3'd5
    } bus_state_t;

    localparam logic [1:0] SEG_EXTRA = 2'b00;
    localparam logic [1:0] SEG_STACK = 2'b01;
    localparam logic [1:0] SEG_CODE  = 2'b10;
    localparam logic [1:0] SEG_DATA  = 2'b11;

    typedef struct packed {
        logic       write;
        logic       mem;
        logic [1:0] seg;
    } req_attr_t;

endpackage

// File: rtl/madb_fsm.sv
module madb_fsm
    import madb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       ready,
    output bus_state_t state,
    output logic       accept
);

    bus_state_t state_q;
    bus_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = ST_T1;
            ST_T1:        state_d = ST_T2;
            ST_T2:        state_d = ST_T3;
            ST_T3, ST_TW: state_d = ready ? ST_T4 : ST_TW;
            ST_T4:        state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    assign state  = state_q;
    assign accept = (state_q == ST_IDLE) && req_valid;

    // R9
    wait_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TW) |-> ($past(state_q) == ST_T3 || $past(state_q) == ST_TW));

    // R9
    wait_on_low_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_T3 || state_q == ST_TW) && !ready) |=> (state_q == ST_TW));

    // R1
    accept_to_t1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (state_q == ST_T1));

endmodule

// File: rtl/madb_req_hold.sv
module madb_req_hold
    import madb_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_state_t        state,
    input  logic              accept,
    input  logic              ready,
    input  req_attr_t         attr_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] ad_in,
    output req_attr_t         attr_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q
);

    logic capture_rd;
    assign capture_rd = (state == ST_T3 || state == ST_TW) && ready && !attr_q.write;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            attr_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            attr_q  <= attr_in;
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          rdata_q <= '0;
        else if (capture_rd) rdata_q <= ad_in;
    end

    // R1
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && state != ST_T1) |-> ($stable(addr_q) && $stable(wdata_q) && $stable(attr_q)));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_T4) |=> $stable(rdata_q));

endmodule

// File: rtl/madb_pin_drive.sv
module madb_pin_drive
    import madb_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  bus_state_t               state,
    input  req_attr_t                attr,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     den_n,
    output logic                     dir,
    output logic                     mio,
    output logic                     ad_oe,
    output logic [DATA_W-1:0]        ad_out,
    output logic [ADDR_W-DATA_W-1:0] as_out
);

    localparam int STAT_W = ADDR_W - DATA_W;

    logic [STAT_W-1:0] status;

    always_comb begin
        status      = '0;
        status[1:0] = attr.seg;
    end

    always_comb begin
        ale    = 1'b0;
        rd_n   = 1'b1;
        wr_n   = 1'b1;
        den_n  = 1'b1;
        dir    = 1'b0;
        mio    = 1'b0;
        ad_oe  = 1'b0;
        ad_out = '0;
        as_out = '0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_T1: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = addr[DATA_W-1:0];
                as_out = addr[ADDR_W-1:DATA_W];
                dir    = attr.write;
                mio    = attr.mem;
            end
            ST_T2, ST_T3, ST_TW: begin
                den_n  = 1'b0;
                dir    = attr.write;
                mio    = attr.mem;
                as_out = status;
                if (attr.write) begin
                    wr_n   = 1'b0;
                    ad_oe  = 1'b1;
                    ad_out = wdata;
                end else begin
                    rd_n   = 1'b0;
                end
            end
            ST_T4: begin
                den_n  = 1'b0;
                dir    = attr.write;
                mio    = attr.mem;
                as_out = status;
                if (attr.write) begin
                    ad_oe  = 1'b1;
                    ad_out = wdata;
                end
            end
            default: begin
            end
        endcase
    end

    // R4
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    // R2
    ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    // R6
    den_after_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !den_n);

    // R7
    dir_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!den_n && $past(!den_n)) |-> $stable(dir));

endmodule

// File: rtl/madb_seq.sv
module madb_seq
    import madb_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic                     req_mem,
    input  logic [1:0]               req_seg,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     done,
    output logic [DATA_W-1:0]        rdata,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic                     den_n,
    output logic                     dir,
    output logic                     mio,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] as_out,
    input  logic [DATA_W-1:0]        ad_in,
    input  logic                     ready
);

    bus_state_t        state;
    logic              accept;
    req_attr_t         attr_in;
    req_attr_t         attr_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    assign attr_in = '{write: req_write, mem: req_mem, seg: req_seg};

    madb_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .ready     (ready),
        .state     (state),
        .accept    (accept)
    );

    madb_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .accept   (accept),
        .ready    (ready),
        .attr_in  (attr_in),
        .addr_in  (req_addr),
        .wdata_in (req_wdata),
        .ad_in    (ad_in),
        .attr_q   (attr_q),
        .addr_q   (addr_q),
        .wdata_q  (wdata_q),
        .rdata_q  (rdata)
    );

    madb_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk    (clk),
        .rst_n  (rst_n),
        .state  (state),
        .attr   (attr_q),
        .addr   (addr_q),
        .wdata  (wdata_q),
        .ale    (ale),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .den_n  (den_n),
        .dir    (dir),
        .mio    (mio),
        .ad_oe  (ad_oe),
        .ad_out (ad_out),
        .as_out (as_out)
    );

    assign req_ready = (state == ST_IDLE);
    assign done      = (state == ST_T4);

    // R2
    accept_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ale);

    // R9
    rd_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n && !ready) |=> !rd_n);

    // R9
    wr_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && !ready) |=> !wr_n);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

endmodule

// File: tb/madb_seq_tb.sv
module madb_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic        req_mem = 1'b0;
    logic [1:0]  req_seg = 2'b00;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        done;
    logic [15:0] rdata;
    logic        ale, rd_n, wr_n, den_n, dir, mio, ad_oe;
    logic [15:0] ad_out;
    logic [3:0]  as_out;
    logic [15:0] ad_in = '0;
    logic        ready = 1'b1;

    always #10 clk = ~clk;

    madb_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_mem(req_mem), .req_seg(req_seg),
        .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
        .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dir(dir), .mio(mio),
        .ad_out(ad_out), .ad_oe(ad_oe), .as_out(as_out), .ad_in(ad_in), .ready(ready)
    );

    typedef struct {
        bit        w;
        bit        mem;
        bit [1:0]  seg;
        bit [19:0] addr;
        bit [15:0] wdata;
        int        waits;
    } item_t;

    item_t exp_q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    finished = 0;

    function automatic logic [15:0] mem_val(input logic [19:0] a);
        return a[15:0] ^ {a[19:16], 12'h5A3};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // driver: holds the request valid while busy; pushes when accepted
    task automatic xfer(input bit w, input bit mem, input bit [1:0] seg,
                        input bit [19:0] a, input bit [15:0] wd, input int waits);
        item_t it;
        it.w = w; it.mem = mem; it.seg = seg; it.addr = a; it.wdata = wd; it.waits = waits;
        req_write = w; req_mem = mem; req_seg = seg; req_addr = a; req_wdata = wd;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        exp_q.push_back(it);
        @(negedge clk);
        req_valid = 1'b0;
        // R1: change fields mid-transfer; must not affect the running one
        req_addr  = ~a;
        req_wdata = ~wd;
        req_seg   = ~seg;
    endtask

    // monitor / device model / scoreboard
    item_t cur;
    bit    active = 0;
    bit    post = 0;
    int    cnt = 0;
    int    low_cnt = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ale) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R2 unexpected ale", 1, 0);
                end else begin
                    cur = exp_q.pop_front();
                    active = 1; cnt = 0; low_cnt = 0;
                    chk(ad_out == cur.addr[15:0], "R2 low address", ad_out, cur.addr[15:0]);
                    chk(as_out == cur.addr[19:16], "R2 high address", as_out, cur.addr[19:16]);
                    chk(ad_oe && rd_n && wr_n, "R2 oe/strobes in T1", {ad_oe, rd_n, wr_n}, 3'b111);
                    chk(den_n == 1'b1, "R6 den high in T1", den_n, 1);
                    chk(dir == cur.w, "R7 dir in T1", dir, cur.w);
                    chk(mio == cur.mem, "R8 mio in T1", mio, cur.mem);
                    chk(req_ready == 1'b0, "R1 busy in T1", req_ready, 0);
                end
            end else if (active) begin
                cnt++;
                chk(req_ready == 1'b0, "R1 busy", req_ready, 0);
                chk(ale == 1'b0, "R2 ale one clock", ale, 0);
                chk(as_out == {2'b00, cur.seg}, "R3 status", as_out, {2'b00, cur.seg});
                chk(den_n == 1'b0, "R6 den low", den_n, 0);
                chk(dir == cur.w, "R7 dir", dir, cur.w);
                chk(mio == cur.mem, "R8 mio", mio, cur.mem);
                if (cur.w) begin
                    chk(ad_oe && ad_out == cur.wdata, "R4 write data", ad_out, cur.wdata);
                    chk(rd_n == 1'b1, "R4 rd_n high on write", rd_n, 1);
                    if (!wr_n) low_cnt++;
                end else begin
                    chk(ad_oe == 1'b0, "R5 lines released", ad_oe, 0);
                    chk(wr_n == 1'b1, "R5 wr_n high on read", wr_n, 1);
                    if (!rd_n) low_cnt++;
                end
                if (done) begin
                    chk(cnt == 3 + cur.waits, "R9 cycle length", cnt + 1, 4 + cur.waits);
                    chk(low_cnt == 2 + cur.waits, "R4 R5 strobe width", low_cnt, 2 + cur.waits);
                    if (!cur.w)
                        chk(rdata == mem_val(cur.addr), "R10 read data", rdata, mem_val(cur.addr));
                    active = 0;
                    post = 1;
                end else if (cnt > 3 + cur.waits) begin
                    chk(0, "R10 done missing", 0, 1);
                    active = 0;
                end
            end else begin
                chk(done == 1'b0, "R10 done outside T4", done, 0);
                if (post) begin
                    chk(req_ready == 1'b1, "R1 idle after done", req_ready, 1);
                    chk(den_n && rd_n && wr_n, "R6 strobes idle", {den_n, rd_n, wr_n}, 3'b111);
                    chk(dir == 1'b0, "R7 dir idle", dir, 0);
                    post = 0;
                end
            end
        end
        ready = !active || (cnt >= 2 + cur.waits);
        ad_in = ready ? mem_val(cur.addr) : 16'hDEAD;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(req_ready == 1'b1, "R11 req_ready", req_ready, 1);
        chk(done == 1'b0 && ale == 1'b0, "R11 done/ale", {done, ale}, 0);
        chk(rd_n && wr_n && den_n, "R11 strobes", {rd_n, wr_n, den_n}, 3'b111);
        rst_n = 1'b1;
        @(negedge clk);
        xfer(1, 1, 2'b11, 20'h3_1234, 16'hBEEF, 0);
        xfer(0, 1, 2'b01, 20'hA_5678, 16'h0000, 0);
        xfer(0, 0, 2'b10, 20'h0_00F0, 16'h0000, 3);
        xfer(1, 0, 2'b00, 20'h7_C001, 16'h1357, 2);
        xfer(0, 1, 2'b11, 20'hF_FFFF, 16'h0000, 1);
        xfer(1, 1, 2'b10, 20'hF_FFFF, 16'hFFFF, 5);
        xfer(0, 1, 2'b00, 20'h0_0000, 16'h0000, 0);
        xfer(1, 0, 2'b01, 20'h0_0000, 16'h0000, 1);
        repeat (30) @(negedge clk);
        chk(exp_q.size() == 0, "R1 all requests issued", exp_q.size(), 0);
        report();
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "R9 watchdog expired", 0, 1);
        report();
    end

endmodule